// File: doc/BRIEF.md
# AXI to AXI-Lite Bridge

This bridge sits between a CPU-side full AXI master and an AXI-Lite register network made of a splitter and register files. It handles only single-beat, full-width, full-strobe accesses. Such reads and writes are forwarded to the AXI-Lite side, and the downstream response code is returned unchanged. The bridge does not break bursts into beats and does not repack byte enables.

Any access that a well-behaved master would never issue is completed locally with a slave error and never reaches the register network. The bridge takes the whole handshake for such an access, including every write data beat up to the last one, so the master never stalls. The transaction ID is captured when the address is accepted and is returned with the response. Each direction allows one transaction in flight at a time.

Top module: `axi2lite_bridge`

## Requirements
- R1: After reset, both address-ready outputs are high, and every valid output on both sides is low.
- R2: A read with length field 0 and size field equal to log2(DATA_W/8) is issued once on the AXI-Lite read address channel with the same address. The downstream read data and response code come back unchanged, together with last=1 and the captured read ID.
- R3: A write with length 0, full size and write strobe all ones is issued on the AXI-Lite address and data channels with the same address and data and a full strobe. The downstream write response code comes back unchanged with the captured write ID.
- R4: A read whose length is not 0 or whose size is not full width never reaches AXI-Lite. It is answered with exactly one read beat carrying response 2'b10, last=1 and the captured ID.
- R5: A write whose length is not 0 or whose size is not full width has all of its data beats accepted up to and including the one with last set. It then gets write response 2'b10 with the captured ID, and it never reaches AXI-Lite.
- R6: A single-beat, full-size write whose strobe is not all ones gets write response 2'b10 and never reaches AXI-Lite.
- R7: After a read address is accepted, the read address ready stays low until the read response handshake completes. The write address ready behaves the same way with respect to the write response.
- R8: Once the bridge raises an AXI-Lite address valid, it holds that valid and its address stable until ready is seen. Once it raises a response valid toward the master, it holds that valid, the ID and the response code stable until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | ID_W | Write address ID |
| s_awaddr | input | ADDR_W | Write address |
| s_awlen | input | 8 | Write burst length minus one |
| s_awsize | input | 3 | Write beat size, log2 bytes |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wlast | input | 1 | Last write beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | ID_W | Read address ID |
| s_araddr | input | ADDR_W | Read address |
| s_arlen | input | 8 | Read burst length minus one |
| s_arsize | input | 3 | Read beat size, log2 bytes |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rid | output | ID_W | Read response ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_awaddr | output | ADDR_W | AXI-Lite write address |
| m_awvalid | output | 1 | AXI-Lite write address valid |
| m_awready | input | 1 | AXI-Lite write address ready |
| m_wdata | output | DATA_W | AXI-Lite write data |
| m_wstrb | output | DATA_W/8 | AXI-Lite write strobes |
| m_wvalid | output | 1 | AXI-Lite write data valid |
| m_wready | input | 1 | AXI-Lite write data ready |
| m_bresp | input | 2 | AXI-Lite write response code |
| m_bvalid | input | 1 | AXI-Lite write response valid |
| m_bready | output | 1 | AXI-Lite write response ready |
| m_araddr | output | ADDR_W | AXI-Lite read address |
| m_arvalid | output | 1 | AXI-Lite read address valid |
| m_arready | input | 1 | AXI-Lite read address ready |
| m_rdata | input | DATA_W | AXI-Lite read data |
| m_rresp | input | 2 | AXI-Lite read response code |
| m_rvalid | input | 1 | AXI-Lite read data valid |
| m_rready | output | 1 | AXI-Lite read data ready |

## Verification
The response-stability assertions assume that the AXI-Lite side keeps its response valid asserted until the bridge accepts it, because a forwarded response is a combinational pass-through. They also assume the master sends write data only after its write address. The bench drives the downstream model so that it raises a response valid only after the address handshake and holds it until the handshake cycle. It issues each write address before its data beats. It also stalls both ready inputs in directed tests, so the hold rules are exercised and not just satisfied trivially.

// File: rtl/axi2lite_bridge.sv
module axi2lite_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ID_W-1:0]       s_awid,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic [7:0]            s_awlen,
  input  logic [2:0]            s_awsize,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  input  logic                  s_wlast,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [ID_W-1:0]       s_bid,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ID_W-1:0]       s_arid,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic [7:0]            s_arlen,
  input  logic [2:0]            s_arsize,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [ID_W-1:0]       s_rid,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rlast,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [ADDR_W-1:0]     m_araddr,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  input  logic [DATA_W-1:0]     m_rdata,
  input  logic [1:0]            m_rresp,
  input  logic                  m_rvalid,
  output logic                  m_rready
);
  localparam int STRB_W = DATA_W / 8;
  localparam logic [2:0] FULL_SIZE = 3'($clog2(STRB_W));
  localparam logic [1:0] SLVERR = 2'b10;

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_RESP, RD_ERR} rd_t;
  typedef enum logic [2:0] {WR_IDLE, WR_DATA, WR_FWD, WR_RESP, WR_ERR} wr_t;

  rd_t               rd_st;
  logic [ID_W-1:0]   rid_q;
  logic [ADDR_W-1:0] raddr_q;
  wire ar_ok = (s_arlen == 8'd0) && (s_arsize == FULL_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_st   <= RD_IDLE;
      rid_q   <= '0;
      raddr_q <= '0;
    end else begin
      case (rd_st)
        RD_IDLE: if (s_arvalid) begin
          rid_q   <= s_arid;
          raddr_q <= s_araddr;
          rd_st   <= ar_ok ? RD_REQ : RD_ERR;
        end
        RD_REQ:  if (m_arready) rd_st <= RD_RESP;
        RD_RESP: if (m_rvalid && s_rready) rd_st <= RD_IDLE;
        default: if (s_rready) rd_st <= RD_IDLE;
      endcase
    end
  end

  assign s_arready = (rd_st == RD_IDLE);
  assign m_arvalid = (rd_st == RD_REQ);
  assign m_araddr  = raddr_q;
  assign s_rvalid  = (rd_st == RD_ERR) || (rd_st == RD_RESP && m_rvalid);
  assign m_rready  = (rd_st == RD_RESP) && s_rready;
  assign s_rdata   = (rd_st == RD_RESP) ? m_rdata : '0;
  assign s_rresp   = (rd_st == RD_ERR) ? SLVERR : m_rresp;
  assign s_rlast   = 1'b1;
  assign s_rid     = rid_q;

  wr_t               wr_st;
  logic [ID_W-1:0]   bid_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              aw_ok_q, bad_q, aw_sent, w_sent;
  wire aw_ok    = (s_awlen == 8'd0) && (s_awsize == FULL_SIZE);
  wire beat_bad = !aw_ok_q || bad_q || (s_wstrb != {STRB_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_st   <= WR_IDLE;
      bid_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      aw_ok_q <= 1'b0;
      bad_q   <= 1'b0;
      aw_sent <= 1'b0;
      w_sent  <= 1'b0;
    end else begin
      case (wr_st)
        WR_IDLE: if (s_awvalid) begin
          bid_q   <= s_awid;
          waddr_q <= s_awaddr;
          aw_ok_q <= aw_ok;
          bad_q   <= 1'b0;
          aw_sent <= 1'b0;
          w_sent  <= 1'b0;
          wr_st   <= WR_DATA;
        end
        WR_DATA: if (s_wvalid) begin
          wdata_q <= s_wdata;
          if (s_wlast) wr_st <= beat_bad ? WR_ERR : WR_FWD;
          else         bad_q <= 1'b1;
        end
        WR_FWD: begin
          if (m_awvalid && m_awready) aw_sent <= 1'b1;
          if (m_wvalid && m_wready)   w_sent  <= 1'b1;
          if ((aw_sent || m_awready) && (w_sent || m_wready)) wr_st <= WR_RESP;
        end
        WR_RESP: if (m_bvalid && s_bready) wr_st <= WR_IDLE;
        default: if (s_bready) wr_st <= WR_IDLE;
      endcase
    end
  end

  assign s_awready = (wr_st == WR_IDLE);
  assign s_wready  = (wr_st == WR_DATA);
  assign m_awvalid = (wr_st == WR_FWD) && !aw_sent;
  assign m_wvalid  = (wr_st == WR_FWD) && !w_sent;
  assign m_awaddr  = waddr_q;
  assign m_wdata   = wdata_q;
  assign m_wstrb   = {STRB_W{1'b1}};
  assign s_bvalid  = (wr_st == WR_ERR) || (wr_st == WR_RESP && m_bvalid);
  assign m_bready  = (wr_st == WR_RESP) && s_bready;
  assign s_bresp   = (wr_st == WR_ERR) ? SLVERR : m_bresp;
  assign s_bid     = bid_q;

  // R7
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |-> !s_arready);
  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |-> !s_awready);
  // R8
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));
  // R8
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
  // R8
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rid) && $stable(s_rresp)));
  // R8
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid) && $stable(s_bresp)));
  // R4
  err_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rresp == SLVERR && !m_rvalid) |-> !m_arvalid);
endmodule

// File: tb/axi2lite_bridge_bench.sv
`timescale 1ns/1ps
module axi2lite_bridge_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [3:0] s_awid, s_arid, s_bid, s_rid;
  logic [31:0] s_awaddr, s_araddr, s_wdata, s_rdata, m_awaddr, m_araddr, m_wdata, m_rdata;
  logic [7:0] s_awlen, s_arlen;
  logic [2:0] s_awsize, s_arsize;
  logic [3:0] s_wstrb, m_wstrb;
  logic s_awvalid, s_awready, s_wlast, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rlast, s_rvalid, s_rready;
  logic [1:0] s_bresp, s_rresp, m_bresp, m_rresp;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready;

  axi2lite_bridge u_axi2lite_bridge (.*);

  typedef struct packed {
    logic wr; logic [3:0] id; logic [31:0] addr; logic [7:0] len; logic [2:0] size;
    logic [3:0] strb; logic [31:0] data; logic [1:0] dresp; logic fwd; logic [1:0] eresp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 4'h3, 32'h10, 8'd0, 3'd2, 4'hF, 32'hA5A5_0001, 2'b00, 1'b1, 2'b00},
    '{1'b0, 4'h5, 32'h44, 8'd0, 3'd2, 4'hF, 32'h1234_5678, 2'b10, 1'b1, 2'b10},
    '{1'b0, 4'h1, 32'h48, 8'd3, 3'd2, 4'hF, 32'h0,         2'b00, 1'b0, 2'b10},
    '{1'b0, 4'h2, 32'h4C, 8'd0, 3'd1, 4'hF, 32'h0,         2'b00, 1'b0, 2'b10},
    '{1'b1, 4'h7, 32'h20, 8'd0, 3'd2, 4'hF, 32'hDEAD_BEEF, 2'b00, 1'b1, 2'b00},
    '{1'b1, 4'h6, 32'h24, 8'd0, 3'd2, 4'hF, 32'h0BAD_F00D, 2'b11, 1'b1, 2'b11},
    '{1'b1, 4'h4, 32'h28, 8'd0, 3'd2, 4'h3, 32'h1111_2222, 2'b00, 1'b0, 2'b10},
    '{1'b1, 4'h9, 32'h2C, 8'd2, 3'd2, 4'hF, 32'h3333_4444, 2'b00, 1'b0, 2'b10},
    '{1'b1, 4'hA, 32'h30, 8'd0, 3'd1, 4'hF, 32'h5555_6666, 2'b00, 1'b0, 2'b10},
    '{1'b0, 4'hF, 32'h34, 8'd0, 3'd2, 4'hF, 32'h7777_8888, 2'b01, 1'b1, 2'b01}
  };

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_read(input vec_t v);
    logic fwd = 0, got = 0, last = 0;
    logic [31:0] fa = 0, rd = 0;
    logic [3:0] id = 0;
    logic [1:0] rr = 0;
    @(negedge clk);
    s_arvalid = 1; s_arid = v.id; s_araddr = v.addr; s_arlen = v.len; s_arsize = v.size;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (m_arvalid) begin
        fwd = 1; fa = m_araddr;
        @(negedge clk);
        m_rvalid = 1; m_rdata = v.data; m_rresp = v.dresp;
        #1;
      end
      if (s_rvalid) begin
        got = 1; id = s_rid; rd = s_rdata; rr = s_rresp; last = s_rlast;
      end
      @(negedge clk);
      m_rvalid = 0;
    end
    chk(v.fwd ? "R2 forwarded" : "R4 not forwarded", 64'(fwd), 64'(v.fwd));
    chk(v.fwd ? "R2 resp" : "R4 slverr", 64'(rr), 64'(v.eresp));
    chk("R2/R4 rid", 64'(id), 64'(v.id));
    chk("R4 rlast", 64'(last & got), 64'd1);
    if (v.fwd) begin
      chk("R2 address", 64'(fa), 64'(v.addr));
      chk("R2 data", 64'(rd), 64'(v.data));
    end
  endtask

  task automatic run_write(input vec_t v);
    logic fwd = 0, got = 0;
    logic [31:0] fa = 0, fd = 0;
    logic [3:0] fs = 0, id = 0;
    logic [1:0] br = 0;
    @(negedge clk);
    s_awvalid = 1; s_awid = v.id; s_awaddr = v.addr; s_awlen = v.len; s_awsize = v.size;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 0;
    for (int b = 0; b <= int'(v.len); b++) begin
      s_wvalid = 1; s_wdata = v.data + 32'(b); s_wstrb = v.strb; s_wlast = (b == int'(v.len));
      while (!s_wready) @(negedge clk);
      @(negedge clk);
    end
    s_wvalid = 0; s_wlast = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (m_awvalid || m_wvalid) begin
        fwd = 1; fa = m_awaddr; fd = m_wdata; fs = m_wstrb;
        @(negedge clk);
        m_bvalid = 1; m_bresp = v.dresp;
        #1;
      end
      if (s_bvalid) begin
        got = 1; id = s_bid; br = s_bresp;
      end
      @(negedge clk);
      m_bvalid = 0;
    end
    chk(v.fwd ? "R3 forwarded" : "R5/R6 not forwarded", 64'(fwd), 64'(v.fwd));
    chk(v.fwd ? "R3 resp" : "R5/R6 slverr", 64'(br), 64'(v.eresp));
    chk("R3 bid", 64'(id & {4{got}}), 64'(v.id));
    if (v.fwd) begin
      chk("R3 address", 64'(fa), 64'(v.addr));
      chk("R3 data", 64'(fd), 64'(v.data));
      chk("R3 strobe", 64'(fs), 64'hF);
    end
  endtask

  initial begin
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_wlast = 0;
    s_awid = 0; s_arid = 0; s_awaddr = 0; s_araddr = 0; s_awlen = 0; s_arlen = 0;
    s_awsize = 0; s_arsize = 0; s_wdata = 0; s_wstrb = 0; s_bready = 1; s_rready = 1;
    m_awready = 1; m_wready = 1; m_arready = 1; m_bvalid = 0; m_rvalid = 0;
    m_bresp = 0; m_rresp = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 arready", 64'(s_arready), 64'd1);
    chk("R1 awready", 64'(s_awready), 64'd1);
    chk("R1 valids", 64'({s_rvalid, s_bvalid, m_arvalid, m_awvalid, m_wvalid}), 64'd0);

    foreach (VEC[i]) begin
      if (VEC[i].wr) run_write(VEC[i]);
      else           run_read(VEC[i]);
    end

    // R8 / R7: stalled AXI-Lite read address, then stalled master read ready
    m_arready = 0;
    @(negedge clk);
    s_arvalid = 1; s_arid = 4'hC; s_araddr = 32'h58; s_arlen = 0; s_arsize = 3'd2;
    @(negedge clk);
    s_arvalid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R8 arvalid held", 64'(m_arvalid), 64'd1);
      chk("R8 araddr stable", 64'(m_araddr), 64'h58);
      chk("R7 arready low", 64'(s_arready), 64'd0);
      @(negedge clk);
    end
    m_arready = 1;
    @(negedge clk);
    m_arready = 1; s_rready = 0; m_rvalid = 1; m_rdata = 32'h99; m_rresp = 2'b00;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R7 arready low while response waits", 64'(s_arready), 64'd0);
      chk("R8 rvalid held", 64'(s_rvalid), 64'd1);
    end
    s_rready = 1;
    @(negedge clk);
    m_rvalid = 0;
    chk("R7 arready back", 64'(s_arready), 64'd1);

    // R8 / R7: stalled AXI-Lite write address
    m_awready = 0;
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'hB; s_awaddr = 32'h60; s_awlen = 0; s_awsize = 3'd2;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 1; s_wdata = 32'hCAFE; s_wstrb = 4'hF; s_wlast = 1;
    @(negedge clk);
    s_wvalid = 0; s_wlast = 0;
    @(negedge clk);
    chk("R8 awvalid held", 64'(m_awvalid), 64'd1);
    chk("R8 wvalid dropped after handshake", 64'(m_wvalid), 64'd0);
    chk("R7 awready low", 64'(s_awready), 64'd0);
    m_awready = 1;
    @(negedge clk);
    m_bvalid = 1; m_bresp = 2'b00;
    #1;
    chk("R3 bid after stall", 64'(s_bid), 64'hB);
    @(negedge clk);
    m_bvalid = 0;
    chk("R7 awready back", 64'(s_awready), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule